// File: doc/BRIEF.md
# SMBus Event Notification Router

This block sits beside an SMBus controller and decides which system notifications each controller event raises. Four kinds of event arrive: an alert-line assertion, a slave write of the wake-or-SMI command, a slave write of the link SMI command, and the host completion and error status bits. Three enable bits and the current power state select among four outputs: a level interrupt request, a host SMI, a slave SMI and a wake pulse.

The rules add together. When several events or conditions hold in the same cycle, every action they call for is raised at once. The block keeps two sticky status bits, one for an alert and one for a slave SMI cause. Software clears each with its own write-one-to-clear strobe. The interrupt and SMI outputs are levels that follow those bits. The host status bits are level inputs and belong to the host engine.

Every port is a plain control or status pin. No data flows through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `smb_event_router`

## Requirements
- R1: A one-cycle `alert_evt` sets `alert_sts` on the next clock edge, whatever the enables are. `alert_sts` stays set until `clr_alert_sts` is high at an edge. When set and clear arrive together, set wins.
- R2: `alert_evt` raises `wake_req` high for exactly the one cycle after the edge that samples it, whatever the enables are.
- R3: An alert sampled with `smi_sel`=1 and `alert_mask`=0 sets `smi_sts`, and `slave_smi` goes high.
- R4: `irq_req` is high whenever `alert_sts`=1, `irq_en`=1, `smi_sel`=0 and `alert_mask`=0.
- R5: With any bit of `host_sts` set: when `irq_en`=0 neither `irq_req` nor `host_smi` rises; when `irq_en`=1 and `smi_sel`=0, `irq_req` is high; when `irq_en`=1 and `smi_sel`=1, `host_smi` is high.
- R6: `wr_wake_evt` sampled with `asleep`=1 gives a one-cycle `wake_req` and leaves `smi_sts` alone. Sampled with `asleep`=0, it sets `smi_sts`.
- R7: `wr_link_evt` sets `smi_sts` only when `asleep`=0. When `asleep`=1 it has no effect on any output.
- R8: Events and conditions that hold in the same cycle raise all of their actions together.
- R9: After reset, every output is 0.
- R10: `slave_smi` follows `smi_sts`. It stays high with no further events until `clr_smi_sts` clears the bit, and `irq_req` drops as soon as `alert_sts` is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alert_evt | input | 1 | One-cycle pulse: alert line seen asserted |
| wr_wake_evt | input | 1 | One-cycle pulse: slave write of the wake-or-SMI command |
| wr_link_evt | input | 1 | One-cycle pulse: slave write of the link SMI command |
| host_sts | input | HOST_STS_W | Host status bits (level) |
| irq_en | input | 1 | Interrupt enable |
| smi_sel | input | 1 | Route to SMI instead of interrupt |
| alert_mask | input | 1 | Blocks alert interrupt and SMI (not wake) |
| asleep | input | 1 | 1 = system sleeping, 0 = in S0 |
| clr_alert_sts | input | 1 | Write-one-to-clear strobe for alert_sts |
| clr_smi_sts | input | 1 | Write-one-to-clear strobe for smi_sts |
| irq_req | output | 1 | Level interrupt request |
| host_smi | output | 1 | Host SMI level |
| slave_smi | output | 1 | Slave SMI level |
| wake_req | output | 1 | One-cycle wake pulse |
| alert_sts | output | 1 | Sticky alert status |
| smi_sts | output | 1 | Sticky slave SMI cause status |

## Verification
The assertions assume that every event input is a single-cycle pulse and that the enables and `asleep` stay steady across the edge that samples an event. Under those assumptions each output is a function of the current state. The stimulus drives every input at the falling edge. It raises each event pulse for exactly one cycle, changes the enables only while no event is pending, and holds `host_sts` only during the cycle in which it is checked.

// File: rtl/smb_rt_pkg.sv
package smb_rt_pkg;
  typedef struct packed {
    logic set_alert;
    logic set_smi;
    logic wake_now;
  } qual_t;
endpackage

// File: rtl/smb_rt_qualify.sv
module smb_rt_qualify
  import smb_rt_pkg::*;
(
  input  logic  alert_evt,
  input  logic  wr_wake_evt,
  input  logic  wr_link_evt,
  input  logic  smi_sel,
  input  logic  alert_mask,
  input  logic  asleep,
  output qual_t q
);
  logic alert_to_smi;
  logic cmd_to_smi;

  always_comb begin
    alert_to_smi = alert_evt & smi_sel & ~alert_mask;
    cmd_to_smi   = (wr_wake_evt | wr_link_evt) & ~asleep;
    q.set_alert  = alert_evt;
    q.set_smi    = alert_to_smi | cmd_to_smi;
    q.wake_now   = alert_evt | (wr_wake_evt & asleep);
  end
endmodule

// File: rtl/smb_rt_sticky.sv
module smb_rt_sticky #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)      q[i] <= 1'b0;
      else if (set[i]) q[i] <= 1'b1;
      else if (clr[i]) q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/smb_rt_notify.sv
module smb_rt_notify #(
  parameter int HOST_STS_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wake_now,
  input  logic                  alert_sts,
  input  logic [HOST_STS_W-1:0] host_sts,
  input  logic                  irq_en,
  input  logic                  smi_sel,
  input  logic                  alert_mask,
  output logic                  irq_req,
  output logic                  host_smi,
  output logic                  wake_req
);
  logic host_any;
  logic alert_irq;

  always_comb begin
    host_any  = |host_sts;
    alert_irq = alert_sts & irq_en & ~smi_sel & ~alert_mask;
    irq_req   = alert_irq | (host_any & irq_en & ~smi_sel);
    host_smi  = host_any & irq_en & smi_sel;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) wake_req <= 1'b0;
    else        wake_req <= wake_now;
  end
endmodule

// File: rtl/smb_event_router.sv
module smb_event_router
  import smb_rt_pkg::*;
#(
  parameter int HOST_STS_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  alert_evt,
  input  logic                  wr_wake_evt,
  input  logic                  wr_link_evt,
  input  logic [HOST_STS_W-1:0] host_sts,
  input  logic                  irq_en,
  input  logic                  smi_sel,
  input  logic                  alert_mask,
  input  logic                  asleep,
  input  logic                  clr_alert_sts,
  input  logic                  clr_smi_sts,
  output logic                  irq_req,
  output logic                  host_smi,
  output logic                  slave_smi,
  output logic                  wake_req,
  output logic                  alert_sts,
  output logic                  smi_sts
);
  localparam int STICKY_W = 2;

  qual_t               qual;
  logic [STICKY_W-1:0] st_q;

  smb_rt_qualify u_qual (
    .alert_evt   (alert_evt),
    .wr_wake_evt (wr_wake_evt),
    .wr_link_evt (wr_link_evt),
    .smi_sel     (smi_sel),
    .alert_mask  (alert_mask),
    .asleep      (asleep),
    .q           (qual)
  );

  smb_rt_sticky #(.W(STICKY_W)) u_sticky (
    .clk   (clk),
    .rst_n (rst_n),
    .set   ({qual.set_smi, qual.set_alert}),
    .clr   ({clr_smi_sts, clr_alert_sts}),
    .q     (st_q)
  );

  assign alert_sts = st_q[0];
  assign smi_sts   = st_q[1];
  assign slave_smi = st_q[1];

  smb_rt_notify #(.HOST_STS_W(HOST_STS_W)) u_notify (
    .clk        (clk),
    .rst_n      (rst_n),
    .wake_now   (qual.wake_now),
    .alert_sts  (alert_sts),
    .host_sts   (host_sts),
    .irq_en     (irq_en),
    .smi_sel    (smi_sel),
    .alert_mask (alert_mask),
    .irq_req    (irq_req),
    .host_smi   (host_smi),
    .wake_req   (wake_req)
  );
endmodule

// File: rtl/smb_event_router_chk.sv
module smb_event_router_chk #(
  parameter int HOST_STS_W = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  alert_evt,
  input logic                  wr_wake_evt,
  input logic                  wr_link_evt,
  input logic [HOST_STS_W-1:0] host_sts,
  input logic                  irq_en,
  input logic                  smi_sel,
  input logic                  alert_mask,
  input logic                  asleep,
  input logic                  clr_smi_sts,
  input logic                  irq_req,
  input logic                  host_smi,
  input logic                  slave_smi,
  input logic                  wake_req,
  input logic                  alert_sts,
  input logic                  smi_sts
);
  a_r1_alert_sets: assert property (@(posedge clk) disable iff (!rst_n)
    alert_evt |=> alert_sts);
  a_r2_alert_wakes: assert property (@(posedge clk) disable iff (!rst_n)
    alert_evt |=> wake_req);
  a_r3_alert_smi: assert property (@(posedge clk) disable iff (!rst_n)
    (alert_evt && smi_sel && !alert_mask) |=> slave_smi);
  a_r5_host_smi: assert property (@(posedge clk) disable iff (!rst_n)
    ((|host_sts) && irq_en && smi_sel) |-> host_smi);
  a_r5_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> (!irq_req && !host_smi));
  a_r6_sleep_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_wake_evt && asleep) |=> wake_req);
  a_r7_link_smi: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_link_evt && !asleep) |=> smi_sts);
  a_r10_smi_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (smi_sts && !clr_smi_sts) |=> (smi_sts && slave_smi));
endmodule

bind smb_event_router smb_event_router_chk #(.HOST_STS_W(HOST_STS_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .alert_evt   (alert_evt),
  .wr_wake_evt (wr_wake_evt),
  .wr_link_evt (wr_link_evt),
  .host_sts    (host_sts),
  .irq_en      (irq_en),
  .smi_sel     (smi_sel),
  .alert_mask  (alert_mask),
  .asleep      (asleep),
  .clr_smi_sts (clr_smi_sts),
  .irq_req     (irq_req),
  .host_smi    (host_smi),
  .slave_smi   (slave_smi),
  .wake_req    (wake_req),
  .alert_sts   (alert_sts),
  .smi_sts     (smi_sts)
);

// File: tb/smb_event_router_test.sv
module smb_event_router_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       alert_evt = 1'b0, wr_wake_evt = 1'b0, wr_link_evt = 1'b0;
  logic [3:0] host_sts = '0;
  logic       irq_en = 1'b0, smi_sel = 1'b0, alert_mask = 1'b0, asleep = 1'b0;
  logic       clr_alert_sts = 1'b0, clr_smi_sts = 1'b0;
  logic       irq_req, host_smi, slave_smi, wake_req, alert_sts, smi_sts;
  int         checks = 0;
  int         failures = 0;

  always #5 clk = ~clk;

  smb_event_router uut (
    .clk(clk), .rst_n(rst_n), .alert_evt(alert_evt), .wr_wake_evt(wr_wake_evt),
    .wr_link_evt(wr_link_evt), .host_sts(host_sts), .irq_en(irq_en),
    .smi_sel(smi_sel), .alert_mask(alert_mask), .asleep(asleep),
    .clr_alert_sts(clr_alert_sts), .clr_smi_sts(clr_smi_sts),
    .irq_req(irq_req), .host_smi(host_smi), .slave_smi(slave_smi),
    .wake_req(wake_req), .alert_sts(alert_sts), .smi_sts(smi_sts)
  );

  // {alert, wr_wake, wr_link, host[3:0], irq_en, smi_sel, mask, asleep,
  //  exp wake, exp alert_sts, exp smi_sts, exp irq, exp host_smi}
  localparam int NV = 14;
  localparam logic [15:0] VEC [NV] = '{
    16'b100_0000_0000_11000,  // R2 R1 alert, nothing enabled
    16'b100_0000_1000_11010,  // R4 alert to interrupt
    16'b100_0000_1010_11000,  // R4 mask blocks interrupt
    16'b100_0000_0100_11100,  // R3 alert to slave SMI
    16'b100_0000_1110_11000,  // R3 mask blocks SMI
    16'b000_0010_0000_00000,  // R5 host status, irq_en off
    16'b000_1000_1000_00010,  // R5 host status to interrupt
    16'b000_0001_1100_00001,  // R5 host status to host SMI
    16'b010_0000_0001_10000,  // R6 wake command asleep
    16'b010_0000_0000_00100,  // R6 wake command awake
    16'b001_0000_0000_00100,  // R7 link command awake
    16'b001_0000_0001_00000,  // R7 link command asleep: ignored
    16'b110_0010_1101_11101,  // R8 alert+wake cmd asleep+host SMI
    16'b101_0100_1000_11110   // R8 alert+link awake+host irq
  };

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic clear_all();
    clr_alert_sts = 1'b1; clr_smi_sts = 1'b1; host_sts = '0;
    @(negedge clk);
    clr_alert_sts = 1'b0; clr_smi_sts = 1'b0;
    irq_en = 1'b0; smi_sel = 1'b0; alert_mask = 1'b0; asleep = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9", "irq_req", irq_req, 1'b0);
    chk("R9", "host_smi", host_smi, 1'b0);
    chk("R9", "slave_smi", slave_smi, 1'b0);
    chk("R9", "wake_req", wake_req, 1'b0);
    chk("R9", "alert_sts", alert_sts, 1'b0);
    chk("R9", "smi_sts", smi_sts, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [15:0] v;
      string tag;
      v = VEC[i];
      tag = $sformatf("vec%0d", i);
      {alert_evt, wr_wake_evt, wr_link_evt} = v[15:13];
      host_sts = v[12:9];
      {irq_en, smi_sel, alert_mask, asleep} = v[8:5];
      @(negedge clk);
      {alert_evt, wr_wake_evt, wr_link_evt} = 3'b000;
      chk(tag, "wake_req", wake_req, v[4]);
      chk(tag, "alert_sts", alert_sts, v[3]);
      chk(tag, "smi_sts", smi_sts, v[2]);
      chk(tag, "irq_req", irq_req, v[1]);
      chk(tag, "host_smi", host_smi, v[0]);
      clear_all();
    end

    // R2: wake is a single-cycle pulse
    alert_evt = 1'b1;
    @(negedge clk);
    alert_evt = 1'b0;
    chk("R2", "wake first cycle", wake_req, 1'b1);
    @(negedge clk);
    chk("R2", "wake second cycle", wake_req, 1'b0);
    chk("R1", "alert_sts held", alert_sts, 1'b1);
    // R4: interrupt follows the enable while status stays set
    irq_en = 1'b1;
    #1 chk("R4", "irq with enable", irq_req, 1'b1);
    smi_sel = 1'b1;
    #1 chk("R4", "irq off with smi_sel", irq_req, 1'b0);
    smi_sel = 1'b0;
    // R1: set wins over a simultaneous clear
    alert_evt = 1'b1; clr_alert_sts = 1'b1;
    @(negedge clk);
    alert_evt = 1'b0; clr_alert_sts = 1'b0;
    chk("R1", "set beats clear", alert_sts, 1'b1);
    // R10: irq drops when alert_sts is cleared
    clr_alert_sts = 1'b1;
    @(negedge clk);
    clr_alert_sts = 1'b0;
    chk("R10", "alert_sts cleared", alert_sts, 1'b0);
    chk("R10", "irq dropped", irq_req, 1'b0);
    irq_en = 1'b0;

    // R10: slave SMI holds until cleared
    wr_link_evt = 1'b1;
    @(negedge clk);
    wr_link_evt = 1'b0;
    repeat (5) @(negedge clk);
    chk("R10", "slave_smi holds", slave_smi, 1'b1);
    clr_smi_sts = 1'b1;
    @(negedge clk);
    clr_smi_sts = 1'b0;
    chk("R10", "slave_smi cleared", slave_smi, 1'b0);

    // R7: link command asleep leaves everything quiet
    asleep = 1'b1; wr_link_evt = 1'b1;
    @(negedge clk);
    wr_link_evt = 1'b0;
    chk("R7", "no smi asleep", smi_sts, 1'b0);
    chk("R7", "no wake from link", wake_req, 1'b0);
    asleep = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule